// File: doc/BRIEF.md
# Four-Slot Parallel Slave Port

This block is the device side of an 8-bit parallel bus. An external host drives chip-select, read and write strobes (and, in one mode, two slot-address pins). The local logic fills slots that the host reads and drains slots that the host writes. Three personalities are selectable. The first is a single shared register. The second is a set of four inbound and four outbound slots visited in turn by two independent rotating pointers. The third is the same eight slots, picked directly by the address pins. The configuration inputs choose the personality, the enable and when the interrupt fires.

All strobes are sampled on the block clock. A host write takes its data and slot address from the last cycle its strobe was active. The write is committed, and the transfer counted, in the clock edge after the strobe drops. A host read is served combinationally while chip select and read are both high. It is counted, with pointer and flag updates, in the clock edge after the strobe drops. Slot occupancy is tracked per slot, so the port raises sticky flags when the host overruns the local side or outruns it.

Top module: `psp_slave`

## Requirements
- R1: With `cfg_mode`=00 every host write lands in slot 0 of the inbound bank, and every host read returns slot 0 of the outbound bank.
- R2: With `cfg_mode`=01, successive host writes go to inbound slots 0,1,2,3,0,... The write pointer restarts at 0 whenever `cfg_en` is low.
- R3: With `cfg_mode`=01, successive host reads return outbound slots 0,1,2,3,0,... The read pointer has its own count and restarts at 0 whenever `cfg_en` is low.
- R4: With `cfg_mode`=10, `host_addr` picks the slot. For a read, the pin value is taken live. For a write, the value held in the last active cycle is used.
- R5: With `cfg_irqm`=01, `irq` pulses high for one cycle, in the cycle after the edge that ends each host read or write.
- R6: With `cfg_irqm`=11 in mode 01, `irq` pulses only for transfers that touch slot 3.
- R7: With `cfg_irqm`=11 in mode 10, `irq` pulses only for transfers made with address 11.
- R8: With `cfg_irqm` 00 or 10, `irq` stays low. In mode 00, setting 11 also leaves `irq` low.
- R9: While `cfg_en` is low, host strobes change nothing and are not served. In the cycle after the enable is seen low, `ovf_flag`, `unf_flag` and `irq` are low.
- R10: `host_oe` is high exactly while the port is enabled, not in mode 11, and both `host_cs` and `host_rd` are high. At all other times `host_dout` is all zeros.
- R11: A host write that ends on an inbound slot still holding unconsumed data sets `ovf_flag`. The flag stays set until `cfg_en` is low.
- R12: A host read that ends on an outbound slot the local side has not refilled since it was last read sets `unf_flag`. The flag stays set until `cfg_en` is low.
- R13: With `cfg_mode`=11 the port ignores host strobes entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Port enable; low also clears pointers and flags |
| cfg_mode | input | 2 | 00 single register, 01 rotating slots, 10 addressed slots, 11 inactive |
| cfg_irqm | input | 2 | 00 none, 01 every transfer, 10 none, 11 slot-3 transfers |
| host_cs | input | 1 | Host chip select, active high |
| host_rd | input | 1 | Host read strobe, active high |
| host_wr | input | 1 | Host write strobe, active high |
| host_addr | input | 2 | Slot address pins (mode 10) |
| host_din | input | 8 | Data from host |
| host_dout | output | 8 | Data to host, zero when not driving |
| host_oe | output | 1 | Data bus drive enable |
| loc_wr | input | 1 | Local fill of an outbound slot |
| loc_widx | input | 2 | Outbound slot to fill |
| loc_wdata | input | 8 | Fill data |
| loc_rd | input | 1 | Local consume of an inbound slot |
| loc_ridx | input | 2 | Inbound slot to view or consume |
| loc_rdata | output | 8 | Content of inbound slot `loc_ridx` |
| irq | output | 1 | One-cycle interrupt pulse |
| ovf_flag | output | 1 | Sticky host-overrun flag |
| unf_flag | output | 1 | Sticky host-underrun flag |

## Verification
The properties are checked on every cycle. They cover the gating of the drive enable and the quiet bus, that each interrupt pulse follows a completed transfer under an interrupting setting, and that both flags stay set while enabled. They also check that disabling clears flags and interrupt, that the single-register mode only targets slot 0, and that the inactive mode completes no transfer. The pointer rotation and wrap, the address selection, slot-3 interrupt filtering, and exactly which transfer first overruns or underruns need sequences of transfers. Only the bench's scenarios show those, through its per-cycle reference model and explicit data and interrupt-count checks.

// File: rtl/psp_pkg.sv
package psp_pkg;

  typedef enum logic [1:0] {
    PM_SINGLE  = 2'b00,
    PM_ROTATE  = 2'b01,
    PM_ADDRESS = 2'b10,
    PM_OFF     = 2'b11
  } port_mode_e;

  typedef enum logic [1:0] {
    IQ_NONE  = 2'b00,
    IQ_EVERY = 2'b01,
    IQ_RSVD  = 2'b10,
    IQ_LAST  = 2'b11
  } irq_mode_e;

  // next position of a rotating pointer over n slots
  function automatic int unsigned ptr_next(int unsigned p, int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  // slot targeted by a transfer for a given personality
  function automatic int unsigned slot_sel(port_mode_e m, int unsigned ptr,
                                           int unsigned addr);
    case (m)
      PM_ROTATE:  return ptr;
      PM_ADDRESS: return addr;
      default:    return 0;
    endcase
  endfunction

  // interrupt decision for the transfers ending this cycle
  function automatic logic irq_fire(irq_mode_e q, port_mode_e m,
                                    logic wr_end, logic rd_end,
                                    int unsigned ws, int unsigned rs,
                                    int unsigned last);
    case (q)
      IQ_EVERY: return wr_end || rd_end;
      IQ_LAST:  return (m == PM_ROTATE || m == PM_ADDRESS) &&
                       ((wr_end && ws == last) || (rd_end && rs == last));
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/psp_strobe.sv
module psp_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic live,
  input  logic clr,
  output logic done
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= live;
  end

  assign done = seen_q && !live && !clr;
endmodule

// File: rtl/psp_bank.sv
module psp_bank #(
  parameter int DW   = 8,
  parameter int NBUF = 4,
  localparam int AW  = $clog2(NBUF)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [AW-1:0]   set_idx,
  input  logic [DW-1:0]   set_data,
  input  logic            clr_en,
  input  logic [AW-1:0]   clr_idx,
  input  logic [AW-1:0]   rd_idx,
  output logic [DW-1:0]   rd_data,
  output logic [NBUF-1:0] full
);
  logic [NBUF-1:0][DW-1:0] flat;

  for (genvar i = 0; i < NBUF; i++) begin : g_slot
    logic [DW-1:0] d_q;
    logic          f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= '0;
        f_q <= 1'b0;
      end else if (set_en && set_idx == AW'(i)) begin
        d_q <= set_data;
        f_q <= 1'b1;
      end else if (clr_en && clr_idx == AW'(i)) begin
        f_q <= 1'b0;
      end
    end
    assign flat[i] = d_q;
    assign full[i] = f_q;
  end

  assign rd_data = flat[rd_idx];
endmodule

// File: rtl/psp_slave.sv
module psp_slave
  import psp_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NBUF = 4,
  localparam int AW  = $clog2(NBUF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic [1:0]    cfg_mode,
  input  logic [1:0]    cfg_irqm,
  input  logic          host_cs,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic          host_oe,
  input  logic          loc_wr,
  input  logic [AW-1:0] loc_widx,
  input  logic [DW-1:0] loc_wdata,
  input  logic          loc_rd,
  input  logic [AW-1:0] loc_ridx,
  output logic [DW-1:0] loc_rdata,
  output logic          irq,
  output logic          ovf_flag,
  output logic          unf_flag
);
  localparam int unsigned LAST = NBUF - 1;

  port_mode_e mode;
  irq_mode_e  iqm;
  assign mode = port_mode_e'(cfg_mode);
  assign iqm  = irq_mode_e'(cfg_irqm);

  logic live, rd_live, wr_live, rd_done, wr_done;
  assign live    = cfg_en && (mode != PM_OFF);
  assign rd_live = live && host_cs && host_rd;
  assign wr_live = live && host_cs && host_wr;

  psp_strobe u_rd_stb (.clk(clk), .rst_n(rst_n), .live(rd_live), .clr(!live), .done(rd_done));
  psp_strobe u_wr_stb (.clk(clk), .rst_n(rst_n), .live(wr_live), .clr(!live), .done(wr_done));

  logic [DW-1:0] wdat_q;
  logic [AW-1:0] addr_q, wptr, rptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdat_q <= '0;
      addr_q <= '0;
    end else begin
      if (wr_live) wdat_q <= host_din;
      if (live && host_cs) addr_q <= host_addr;
    end
  end

  logic [AW-1:0] wr_slot, rd_slot, rd_live_slot;
  assign wr_slot      = AW'(slot_sel(mode, 32'(wptr), 32'(addr_q)));
  assign rd_slot      = AW'(slot_sel(mode, 32'(rptr), 32'(addr_q)));
  assign rd_live_slot = AW'(slot_sel(mode, 32'(rptr), 32'(host_addr)));

  logic [NBUF-1:0] wfull, rfull;
  logic [DW-1:0]   rbuf_data;

  psp_bank #(.DW(DW), .NBUF(NBUF)) u_inbound (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr_done), .set_idx(wr_slot), .set_data(wdat_q),
    .clr_en(loc_rd), .clr_idx(loc_ridx),
    .rd_idx(loc_ridx), .rd_data(loc_rdata), .full(wfull)
  );

  psp_bank #(.DW(DW), .NBUF(NBUF)) u_outbound (
    .clk(clk), .rst_n(rst_n),
    .set_en(loc_wr), .set_idx(loc_widx), .set_data(loc_wdata),
    .clr_en(rd_done), .clr_idx(rd_slot),
    .rd_idx(rd_live_slot), .rd_data(rbuf_data), .full(rfull)
  );

  assign host_oe   = rd_live;
  assign host_dout = rd_live ? rbuf_data : '0;

  logic ovr_evt, und_evt, irq_evt;
  assign ovr_evt = wr_done && wfull[wr_slot];
  assign und_evt = rd_done && !rfull[rd_slot];
  assign irq_evt = irq_fire(iqm, mode, wr_done, rd_done, 32'(wr_slot), 32'(rd_slot), LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
      irq      <= 1'b0;
    end else if (!cfg_en) begin
      wptr     <= '0;
      rptr     <= '0;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr_done && mode == PM_ROTATE) wptr <= AW'(ptr_next(32'(wptr), NBUF));
      if (rd_done && mode == PM_ROTATE) rptr <= AW'(ptr_next(32'(rptr), NBUF));
      if (ovr_evt) ovf_flag <= 1'b1;
      if (und_evt) unf_flag <= 1'b1;
      irq <= irq_evt;
    end
  end
endmodule

// File: rtl/psp_slave_chk.sv
module psp_slave_chk #(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic [1:0]    cfg_mode,
  input logic [1:0]    cfg_irqm,
  input logic          host_cs,
  input logic          host_rd,
  input logic          host_oe,
  input logic [DW-1:0] host_dout,
  input logic          irq,
  input logic          ovf_flag,
  input logic          unf_flag,
  input logic          wr_done,
  input logic          rd_done,
  input logic [AW-1:0] wr_slot
);
  p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_oe |-> (host_cs && host_rd && cfg_en && cfg_mode != 2'b11));

  p_dout_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !host_oe |-> host_dout == '0);

  p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(wr_done || rd_done));

  p_irq_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(cfg_irqm) == 2'b01 || $past(cfg_irqm) == 2'b11));

  p_single_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && cfg_mode == 2'b00) |-> wr_slot == '0);

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (!irq && !ovf_flag && !unf_flag));

  p_ovf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> (ovf_flag || !$past(cfg_en)));

  p_unf_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |=> (unf_flag || !$past(cfg_en)));

  p_off_mode_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode == 2'b11 |-> (!host_oe && !wr_done && !rd_done));
endmodule

bind psp_slave psp_slave_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
  .cfg_irqm(cfg_irqm), .host_cs(host_cs), .host_rd(host_rd),
  .host_oe(host_oe), .host_dout(host_dout), .irq(irq),
  .ovf_flag(ovf_flag), .unf_flag(unf_flag), .wr_done(wr_done),
  .rd_done(rd_done), .wr_slot(wr_slot)
);

// File: tb/psp_slave_test.sv
module psp_slave_test;
  logic clk = 0, rst_n = 0;
  logic cfg_en = 0;
  logic [1:0] cfg_mode = 0, cfg_irqm = 0;
  logic host_cs = 0, host_rd = 0, host_wr = 0;
  logic [1:0] host_addr = 0;
  logic [7:0] host_din = 0;
  logic [7:0] host_dout;
  logic host_oe;
  logic loc_wr = 0, loc_rd = 0;
  logic [1:0] loc_widx = 0, loc_ridx = 0;
  logic [7:0] loc_wdata = 0;
  logic [7:0] loc_rdata;
  logic irq, ovf_flag, unf_flag;

  int checks = 0, errors = 0, irq_seen = 0;
  bit done_flag = 0;

  psp_slave uut (.*);

  always #10 clk = ~clk;

  // behavioural reference state
  int m_wb[4], m_rb[4];
  bit m_wf[4], m_rf[4];
  int m_wp, m_rp, m_addr, m_wd;
  bit m_rq, m_wq, m_irq, m_ovf, m_unf;

  function automatic int pick(int mode, int ptr, int a);
    if (mode == 1) return ptr;
    if (mode == 2) return a;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_wb[i] = 0; m_rb[i] = 0; m_wf[i] = 0; m_rf[i] = 0; end
      m_wp = 0; m_rp = 0; m_addr = 0; m_wd = 0;
      m_rq = 0; m_wq = 0; m_irq = 0; m_ovf = 0; m_unf = 0;
    end else begin
      bit lv, rl, wl, rdn, wdn, fire, oflow, uflow;
      int ws, rs;
      lv  = cfg_en && cfg_mode != 3;
      rl  = lv && host_cs && host_rd;
      wl  = lv && host_cs && host_wr;
      rdn = m_rq && !rl && lv;
      wdn = m_wq && !wl && lv;
      ws  = pick(cfg_mode, m_wp, m_addr);
      rs  = pick(cfg_mode, m_rp, m_addr);
      fire = 0;
      if (cfg_irqm == 1) fire = rdn || wdn;
      if (cfg_irqm == 3 && cfg_mode != 0) fire = (wdn && ws == 3) || (rdn && rs == 3);
      oflow = wdn && m_wf[ws];
      uflow = rdn && !m_rf[rs];
      if (loc_rd) m_wf[loc_ridx] = 0;
      if (wdn) begin m_wb[ws] = m_wd; m_wf[ws] = 1; end
      if (rdn) m_rf[rs] = 0;
      if (loc_wr) begin m_rb[loc_widx] = loc_wdata; m_rf[loc_widx] = 1; end
      if (!cfg_en) begin
        m_wp = 0; m_rp = 0; m_ovf = 0; m_unf = 0; m_irq = 0;
      end else begin
        if (wdn && cfg_mode == 1) m_wp = (m_wp + 1) % 4;
        if (rdn && cfg_mode == 1) m_rp = (m_rp + 1) % 4;
        if (oflow) m_ovf = 1;
        if (uflow) m_unf = 1;
        m_irq = fire;
      end
      m_rq = rl; m_wq = wl;
      if (wl) m_wd = host_din;
      if (lv && host_cs) m_addr = host_addr;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      bit eo;
      int ed;
      string dtag, itag;
      eo = cfg_en && cfg_mode != 3 && host_cs && host_rd;
      ed = eo ? m_rb[pick(cfg_mode, m_rp, host_addr)] : 0;
      dtag = (cfg_mode == 0) ? "R1" : (cfg_mode == 1) ? "R3" : "R4";
      itag = (cfg_irqm == 1) ? "R5" : (cfg_irqm == 3) ? ((cfg_mode == 1) ? "R6" : "R7") : "R8";
      check(host_oe == eo, "R10 oe", host_oe, eo);
      check(host_dout == ed[7:0], dtag, host_dout, ed);
      check(irq == m_irq, itag, irq, m_irq);
      check(ovf_flag == m_ovf, "R11", ovf_flag, m_ovf);
      check(unf_flag == m_unf, "R12", unf_flag, m_unf);
      check(loc_rdata == m_wb[loc_ridx][7:0], (cfg_mode == 1) ? "R2" : dtag, loc_rdata, m_wb[loc_ridx]);
      if (irq) irq_seen++;
    end
  end

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic setup(bit en, logic [1:0] md, logic [1:0] iq);
    step(); cfg_en = en; cfg_mode = md; cfg_irqm = iq;
  endtask

  task automatic recycle();
    step(); cfg_en = 0; step(); step(); cfg_en = 1;
  endtask

  task automatic host_write(logic [1:0] a, logic [7:0] d);
    step(); host_cs = 1; host_wr = 1; host_addr = a; host_din = d;
    step(); host_cs = 0; host_wr = 0;
    step();
  endtask

  task automatic host_read(logic [1:0] a, output logic [7:0] v, output logic o);
    step(); host_cs = 1; host_rd = 1; host_addr = a;
    #1 v = host_dout; o = host_oe;
    step(); host_cs = 0; host_rd = 0;
    step();
  endtask

  task automatic local_fill(logic [1:0] i, logic [7:0] d);
    step(); loc_wr = 1; loc_widx = i; loc_wdata = d;
    step(); loc_wr = 0;
  endtask

  task automatic local_take(logic [1:0] i);
    step(); loc_rd = 1; loc_ridx = i;
    step(); loc_rd = 0;
  endtask

  task automatic peek(logic [1:0] i, output logic [7:0] v);
    step(); loc_ridx = i; #1 v = loc_rdata;
  endtask

  initial begin
    logic [7:0] v;
    logic o;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    check(host_oe == 0, "R10 reset oe", host_oe, 0);
    check(irq == 0, "R5 reset irq", irq, 0);
    check(ovf_flag == 0, "R11 reset", ovf_flag, 0);
    check(unf_flag == 0, "R12 reset", unf_flag, 0);

    // single register, irq on every transfer
    setup(1, 2'b00, 2'b01);
    base = irq_seen;
    local_fill(2'd0, 8'hA5);
    host_write(2'd2, 8'h3C);
    host_read(2'd3, v, o);
    check(v == 8'hA5, "R1 read", v, 8'hA5);
    check(o == 1, "R10 drive", o, 1);
    peek(2'd0, v);
    check(v == 8'h3C, "R1 write", v, 8'h3C);
    local_take(2'd0);
    step();
    check(irq_seen - base == 2, "R5 count", irq_seen - base, 2);

    // disabled: strobes ignored
    setup(0, 2'b00, 2'b01);
    host_write(2'd0, 8'hEE);
    host_read(2'd0, v, o);
    check(o == 0, "R9 no drive", o, 0);
    peek(2'd0, v);
    check(v == 8'h3C, "R9 unchanged", v, 8'h3C);

    // rotating slots, slot-3 interrupt
    setup(1, 2'b01, 2'b11);
    base = irq_seen;
    for (int i = 0; i < 4; i++) local_fill(2'(i), 8'(8'h10 + i));
    for (int i = 0; i < 5; i++) host_write(2'd0, 8'(8'h20 + i));
    check(ovf_flag == 1, "R11 overrun", ovf_flag, 1);
    peek(2'd1, v);
    check(v == 8'h21, "R2 order", v, 8'h21);
    peek(2'd0, v);
    check(v == 8'h24, "R2 wrap", v, 8'h24);
    for (int i = 0; i < 5; i++) begin
      host_read(2'd2, v, o);
      check(v == 8'(8'h10 + (i % 4)), "R3 sequence", v, 8'h10 + (i % 4));
    end
    check(unf_flag == 1, "R12 underrun", unf_flag, 1);
    step();
    check(irq_seen - base == 2, "R6 count", irq_seen - base, 2);

    // addressed slots
    recycle();
    setup(1, 2'b10, 2'b11);
    check(ovf_flag == 0 && unf_flag == 0, "R9 flags cleared", {ovf_flag, unf_flag}, 0);
    base = irq_seen;
    local_fill(2'd2, 8'h77);
    host_read(2'd2, v, o);
    check(v == 8'h77, "R4 read", v, 8'h77);
    host_write(2'd3, 8'h99);
    peek(2'd3, v);
    check(v == 8'h99, "R4 write", v, 8'h99);
    step();
    check(irq_seen - base == 1, "R7 count", irq_seen - base, 1);

    // silent interrupt settings
    base = irq_seen;
    setup(1, 2'b10, 2'b00);
    host_write(2'd3, 8'h41);
    setup(1, 2'b10, 2'b10);
    host_write(2'd3, 8'h42);
    setup(1, 2'b00, 2'b11);
    host_write(2'd0, 8'h43);
    step();
    check(irq_seen - base == 0, "R8 count", irq_seen - base, 0);

    // inactive mode
    setup(1, 2'b11, 2'b01);
    peek(2'd1, v);
    base = v;
    host_write(2'd1, 8'h5A);
    host_read(2'd1, v, o);
    check(o == 0, "R13 no drive", o, 0);
    peek(2'd1, v);
    check(v == 8'(base), "R13 unchanged", v, base);

    repeat (3) step();
    if (!done_flag) begin
      done_flag = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule